// File: doc/BRIEF.md
# Prefixed Add-Immediate Execute Unit

This unit executes the add-immediate operation of a 32-bit instruction stream. There are two encodings. A single word holds a 16-bit signed immediate. A two-word pair holds a 34-bit signed immediate: a prefix word carries the upper 18 bits and a mode flag, and the suffix word that follows carries the lower 16 bits. With the mode flag clear, the operand base is a general-purpose register, and register number zero reads as the constant zero. With the flag set, the base is the address of the prefix word.

The front end presents one word per cycle with a valid strobe and the address of that word. The unit reads the register file through a combinational read port that it drives from the register-field bits of the word. One cycle after the unit accepts a plain word or a suffix, it gives a 64-bit sum, a destination register number and a single-cycle write strobe. A prefix on its own produces nothing. The unit holds the prefix fields until the next valid word arrives. A word the unit does not recognise, or a prefix followed by anything other than an add-immediate suffix, gives a one-cycle illegal pulse and no write.

Top module: `addimm_exec`

## Requirements
- R1: A valid word with opcode 14 in word bits 31:26 (bit 0 in MSB-first numbering), arriving with no prefix pending, is a plain add. One cycle later the unit asserts out_wen with out_rd = word[25:21]. In that cycle out_result = base + sign-extended word[15:0], where base is the register that word[20:16] selects.
- R2: A register field of zero, word[20:16] = 0, gives base 0 whatever the register file holds at index 0.
- R3: A valid word with word[31:26] = 1, word[25:24] = 2'b10 and word[23] = 0 is a prefix. The next cycle shows neither out_wen nor out_illegal. The unit keeps the mode flag word[20] and the upper immediate word[17:0], and also the word's address.
- R4: A suffix has opcode 14 and follows a prefix whose mode flag is 0. Its result is base(word[20:16]) + sign-extend64({prefix[17:0], suffix[15:0]}), with out_rd = suffix[25:21].
- R5: A suffix follows a prefix whose mode flag is 1. Its result is the prefix word's address + the same sign-extended 34-bit immediate. The register field of the suffix is ignored even when it is nonzero.
- R6: A prefix may be followed by a valid word whose opcode is not 14, including another prefix. That word gives out_illegal for one cycle and no write, and it clears the pending prefix. The next opcode-14 word is then a plain add.
- R7: With no prefix pending, any valid word that is neither an opcode-14 word nor a prefix as defined in R3 gives out_illegal for one cycle and no write.
- R8: Each accepted word gives at most one output event, one cycle after acceptance. out_wen and out_illegal are never high together. A cycle without in_valid produces no event and leaves a pending prefix in place.
- R9: A synchronous active-high reset clears the pending prefix and drives out_wen, out_illegal, out_rd and out_result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word valid |
| in_word | input | 32 | Instruction word (bit 31 is MSB-first bit 0) |
| in_addr | input | 64 | Address of in_word |
| rf_raddr | output | 5 | Register-file read index (word[20:16]) |
| rf_rdata | input | 64 | Register-file read data, combinational |
| out_wen | output | 1 | Write strobe, one cycle per executed add |
| out_rd | output | 5 | Destination register |
| out_result | output | 64 | Sum to be written |
| out_illegal | output | 1 | Unrecognised word or bad suffix pulse |

## Verification
The assertions take for granted that rf_rdata is a settled function of rf_raddr within the cycle, and that in_word and in_addr are stable while in_valid is high at the clock edge. The bench models the register file as a combinational array lookup, with nonzero contents at index 0 to expose R2. It changes every input only just after a rising edge. Gaps without in_valid fall between a prefix and its suffix, and also between unrelated words, so the pending hold is exercised under both conditions.

// File: rtl/addimm_pkg.sv
package addimm_pkg;
    localparam int WORD_W   = 32;
    localparam int XLEN     = 64;
    localparam int REG_N    = 32;
    localparam int REG_AW   = $clog2(REG_N);
    localparam int IMM_LO_W = 16;
    localparam int IMM_HI_W = 18;
    localparam int IMM_W    = IMM_LO_W + IMM_HI_W;
    localparam int OPC_W    = 6;

    localparam logic [OPC_W-1:0] OPC_ADDI = 6'd14;
    localparam logic [OPC_W-1:0] OPC_PFX  = 6'd1;

    typedef enum logic [1:0] {
        K_ADD = 2'd0,
        K_PFX = 2'd1,
        K_BAD = 2'd2
    } kind_e;

    typedef struct packed {
        kind_e                kind;
        logic [REG_AW-1:0]    rt;
        logic [REG_AW-1:0]    ra;
        logic [IMM_LO_W-1:0]  imm_lo;
        logic                 rel;
        logic [IMM_HI_W-1:0]  imm_hi;
    } dec_t;

    typedef struct packed {
        logic                 rel;
        logic [IMM_HI_W-1:0]  imm_hi;
        logic [XLEN-1:0]      addr;
    } pfx_t;

    function automatic logic [XLEN-1:0] sext_lo(input logic [IMM_LO_W-1:0] v);
        return {{(XLEN-IMM_LO_W){v[IMM_LO_W-1]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] sext_full(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction
endpackage

// File: rtl/addimm_decode.sv
module addimm_decode
    import addimm_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output dec_t              dec
);
    logic [OPC_W-1:0] opc;

    always_comb begin
        opc        = word[WORD_W-1 -: OPC_W];
        dec.rt     = word[25:21];
        dec.ra     = word[20:16];
        dec.imm_lo = word[IMM_LO_W-1:0];
        dec.rel    = word[20];
        dec.imm_hi = word[IMM_HI_W-1:0];
        if (opc == OPC_ADDI)
            dec.kind = K_ADD;
        else if (opc == OPC_PFX && word[25:24] == 2'b10 && !word[23])
            dec.kind = K_PFX;
        else
            dec.kind = K_BAD;
    end
endmodule

// File: rtl/addimm_prefix_hold.sv
module addimm_prefix_hold
    import addimm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  dec_t            dec,
    input  logic [XLEN-1:0] addr,
    output logic            pending,
    output pfx_t            held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            held    <= '0;
        end else if (take) begin
            if (!pending && dec.kind == K_PFX) begin
                pending     <= 1'b1;
                held.rel    <= dec.rel;
                held.imm_hi <= dec.imm_hi;
                held.addr   <= addr;
            end else begin
                pending <= 1'b0;
            end
        end
    end

    assert_arm_R3: assert property (@(posedge clk) disable iff (rst)
        (take && !pending && dec.kind == K_PFX) |=> pending);
    assert_consume_R6: assert property (@(posedge clk) disable iff (rst)
        (take && pending) |=> !pending);
    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!take && pending) |=> pending);
endmodule

// File: rtl/addimm_exec.sv
module addimm_exec
    import addimm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic [XLEN-1:0]   in_addr,
    output logic [REG_AW-1:0] rf_raddr,
    input  logic [XLEN-1:0]   rf_rdata,
    output logic              out_wen,
    output logic [REG_AW-1:0] out_rd,
    output logic [XLEN-1:0]   out_result,
    output logic              out_illegal
);
    dec_t            dec;
    logic            pending;
    pfx_t            held;
    logic            go_plain, go_sfx, go_bad;
    logic [XLEN-1:0] base, imm, sum;

    addimm_decode u_dec (
        .word (in_word),
        .dec  (dec)
    );

    addimm_prefix_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .take    (in_valid),
        .dec     (dec),
        .addr    (in_addr),
        .pending (pending),
        .held    (held)
    );

    assign rf_raddr = dec.ra;

    always_comb begin
        go_plain = in_valid && !pending && dec.kind == K_ADD;
        go_sfx   = in_valid &&  pending && dec.kind == K_ADD;
        go_bad   = in_valid && (pending ? (dec.kind != K_ADD) : (dec.kind == K_BAD));
        if (go_sfx && held.rel)
            base = held.addr;
        else if (dec.ra == '0)
            base = '0;
        else
            base = rf_rdata;
        imm = go_sfx ? sext_full({held.imm_hi, dec.imm_lo}) : sext_lo(dec.imm_lo);
        sum = base + imm;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_wen     <= 1'b0;
            out_illegal <= 1'b0;
            out_rd      <= '0;
            out_result  <= '0;
        end else begin
            out_wen     <= go_plain || go_sfx;
            out_illegal <= go_bad;
            if (go_plain || go_sfx) begin
                out_rd     <= dec.rt;
                out_result <= sum;
            end
        end
    end

    assert_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(out_wen && out_illegal));
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_wen && !out_illegal));
    assert_plain_write_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !pending && dec.kind == K_ADD) |=> (out_wen && out_rd == $past(in_word[25:21])));
    assert_zero_base_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !pending && dec.kind == K_ADD && in_word[20:0] == 21'd0) |=> (out_result == '0));
    assert_bad_suffix_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pending && dec.kind != K_ADD) |=> (out_illegal && !out_wen));
    assert_prefix_silent_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !pending && dec.kind == K_PFX) |=> (!out_wen && !out_illegal));
    assert_unknown_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !pending && dec.kind == K_BAD) |=> out_illegal);
endmodule

// File: tb/addimm_exec_tb.sv
module addimm_exec_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic [63:0] in_addr = '0;
    logic [4:0]  rf_raddr;
    logic [63:0] rf_rdata;
    logic        out_wen, out_illegal;
    logic [4:0]  out_rd;
    logic [63:0] out_result;

    logic [63:0] rf [32];
    assign rf_rdata = rf[rf_raddr];

    always #(CLK_PERIOD/2) clk = ~clk;

    addimm_exec u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .in_addr(in_addr), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .out_wen(out_wen), .out_rd(out_rd), .out_result(out_result),
        .out_illegal(out_illegal)
    );

    typedef struct {
        logic        ill;
        logic [4:0]  rd;
        logic [63:0] res;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    bit          m_pend = 0;
    bit          m_rel;
    logic [17:0] m_hi;
    logic [63:0] m_addr;

    function automatic logic [31:0] mk_d(input logic [5:0] opc, input logic [4:0] rt,
                                         input logic [4:0] ra, input logic [15:0] imm);
        return {opc, rt, ra, imm};
    endfunction

    function automatic logic [31:0] mk_pfx(input logic rel, input logic [17:0] hi);
        return {6'd1, 2'b10, 1'b0, 2'b00, rel, 2'b00, hi};
    endfunction

    function automatic logic [63:0] base_of(input logic [4:0] ra);
        return (ra == 5'd0) ? 64'd0 : rf[ra];
    endfunction

    task automatic push(input logic ill, input logic [4:0] rd, input logic [63:0] res, input string tag);
        exp_t e;
        e.ill = ill; e.rd = rd; e.res = res; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic send(input logic [31:0] w, input logic [63:0] a, input string tag);
        logic [5:0]  opc;
        logic [33:0] imm34;
        logic [63:0] r;
        opc = w[31:26];
        if (m_pend) begin
            m_pend = 0;
            if (opc == 6'd14) begin
                imm34 = {m_hi, w[15:0]};
                r = (m_rel ? m_addr : base_of(w[20:16])) + {{30{imm34[33]}}, imm34};
                push(1'b0, w[25:21], r, tag);
            end else begin
                push(1'b1, 5'd0, 64'd0, tag);
            end
        end else if (opc == 6'd14) begin
            r = base_of(w[20:16]) + {{48{w[15]}}, w[15:0]};
            push(1'b0, w[25:21], r, tag);
        end else if (opc == 6'd1 && w[25:24] == 2'b10 && !w[23]) begin
            m_pend = 1; m_rel = w[20]; m_hi = w[17:0]; m_addr = a;
        end else begin
            push(1'b1, 5'd0, 64'd0, tag);
        end
        in_valid = 1'b1; in_word = w; in_addr = a;
        @(posedge clk); #1;
        in_valid = 1'b0; in_word = $urandom;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic fail_line(input string tag, input string what, input logic [63:0] act, input logic [63:0] expv);
        n_bad++;
        $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    endtask

    always @(negedge clk) begin
        if (!rst && !done && (out_wen || out_illegal)) begin
            exp_t e;
            n_cmp++;
            if (exp_q.size() == 0) begin
                fail_line("R8", "unexpected event wen/ill", {62'd0, out_wen, out_illegal}, 64'd0);
            end else begin
                e = exp_q.pop_front();
                if (out_illegal !== e.ill || out_wen !== !e.ill)
                    fail_line(e.tag, "event kind (ill)", {63'd0, out_illegal}, {63'd0, e.ill});
                else if (!e.ill && out_rd !== e.rd)
                    fail_line(e.tag, "dest", {59'd0, out_rd}, {59'd0, e.rd});
                else if (!e.ill && out_result !== e.res)
                    fail_line(e.tag, "result", out_result, e.res);
            end
        end
    end

    task automatic do_reset();
        rst = 1'b1; m_pend = 0; exp_q.delete();
        idle(2);
        rst = 1'b0;
        @(negedge clk);
        n_cmp++;
        if (out_wen !== 1'b0 || out_illegal !== 1'b0 || out_rd !== 5'd0 || out_result !== 64'd0)
            fail_line("R9", "outputs after reset", out_result, 64'd0);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) rf[i] = {$urandom, $urandom};
        rf[0] = 64'hDEAD_BEEF_0000_1111;
        rf[3] = 64'd1000;
        rf[7] = 64'h0000_0000_FFFF_FFFF;

        do_reset();

        send(mk_d(6'd14, 5'd5, 5'd3, 16'd25), 64'h100, "R1");
        send(mk_d(6'd14, 5'd6, 5'd3, 16'hFFF0), 64'h104, "R1");
        send(mk_d(6'd14, 5'd9, 5'd0, 16'h7FFF), 64'h108, "R2");
        send(mk_d(6'd14, 5'd9, 5'd0, 16'h8000), 64'h10C, "R2");

        send(mk_pfx(1'b0, 18'h20000), 64'h200, "R3");
        idle(1);
        send(mk_d(6'd14, 5'd10, 5'd7, 16'h0001), 64'h208, "R4");
        send(mk_pfx(1'b0, 18'h00003), 64'h210, "R3");
        send(mk_d(6'd14, 5'd11, 5'd0, 16'h1234), 64'h218, "R4");

        send(mk_pfx(1'b1, 18'h3FFFF), 64'h1000, "R5");
        idle(3);
        send(mk_d(6'd14, 5'd12, 5'd7, 16'hFF00), 64'h1008, "R5");
        send(mk_pfx(1'b1, 18'h00010), 64'h2000, "R5");
        send(mk_d(6'd14, 5'd13, 5'd31, 16'h0004), 64'h2008, "R5");

        send(mk_pfx(1'b0, 18'h00001), 64'h300, "R6");
        send(mk_d(6'd31, 5'd1, 5'd3, 16'h0005), 64'h308, "R6");
        send(mk_d(6'd14, 5'd14, 5'd3, 16'h0005), 64'h30C, "R6");
        send(mk_pfx(1'b0, 18'h00001), 64'h310, "R6");
        send(mk_pfx(1'b1, 18'h00002), 64'h318, "R6");
        send(mk_d(6'd14, 5'd15, 5'd3, 16'h0007), 64'h320, "R6");

        send(mk_d(6'd7, 5'd1, 5'd2, 16'h0), 64'h400, "R7");
        send({6'd1, 2'b01, 1'b0, 23'd5}, 64'h404, "R7");
        send({6'd1, 2'b10, 1'b1, 23'd5}, 64'h408, "R7");
        send(mk_d(6'd14, 5'd16, 5'd3, 16'd1), 64'h40C, "R8");
        idle(2);

        send(mk_pfx(1'b1, 18'h00005), 64'h500, "R9");
        do_reset();
        send(mk_d(6'd14, 5'd17, 5'd3, 16'd2), 64'h504, "R9");

        for (int k = 0; k < 300; k++) begin
            int sel;
            logic [31:0] w;
            logic [63:0] a;
            sel = $urandom_range(0, 9);
            a = {$urandom, $urandom};
            w = $urandom;
            if (sel < 4)      w[31:26] = 6'd14;
            else if (sel < 8) w = mk_pfx(w[20], w[17:0]);
            if (sel == 5) idle(1);
            send(w, a, sel < 4 ? "R1" : (sel < 8 ? "R4" : "R7"));
        end
        idle(3);

        done = 1;
        while (exp_q.size() != 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_cmp++;
            fail_line(e.tag, "missing event", 64'd0, 64'd1);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule